// File: doc/BRIEF.md
# Flash Command Sequence Controller

This block sits between a byte-wide host write bus and the program/erase engine of a 512 KB flash array. It turns streams of host writes into operations. Every command apart from the return to read mode begins with a two-write unlock prefix. Several operations can follow the prefix: identification, byte program, whole-array erase, and sector erase. A sector erase can gather several sectors into one batch, using an accept window that starts again on each new sector. A running sector erase can be suspended and later resumed.

Writes arrive as a stream on `wr_valid` with address and data. `wr_ready` is held high, so the block never applies back-pressure: every write is taken in the cycle in which `wr_valid` is high. A write the current phase does not accept has no effect. The phase is shown on plain level outputs: `window_open`, `erasing`, `programming`, `suspended` and `asel_mode`. These come with the sector mask under erase and the latched program address and data. A status generator or array engine can use them directly. Operation run times come from parameterised cycle counts. The protect inputs are expected to stay stable while an operation is queued or running.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset the controller is in read mode: `window_open`, `erasing`, `programming`, `suspended` and `asel_mode` are low, `erase_mask`, `prog_addr`, `prog_data` and `asel_code` are zero, and `wr_ready` is high.
- R2: The sequence AAh at key 5555h, 55h at key 2AAAh, A0h at key 5555h, then one write of address and data starts a program. The key is address bits 14:0; bits 18:15 are ignored. The cycle after the final write, `programming` rises and stays high for PROG_CYC cycles. During that time `prog_addr` and `prog_data` show the values from the final write.
- R3: A wrong data or key value in either unlock write, or an unknown command byte in the third write, returns the controller to read mode with nothing started. A following program address/data write has no effect.
- R4: After unlock plus 90h at key 5555h, `asel_mode` is high. `asel_code` is 01h when `rd_addr` has in-sector offset (bits 15:0) 0002h in a protected sector. It is 00h for an unprotected sector or any other offset.
- R5: Unlock, 80h at 5555h, a second unlock, then 10h at 5555h starts a whole-array erase. `erasing` is high for ERASE_CYC cycles and `erase_mask` equals the inverse of `prot`.
- R6: Unlock, 80h, unlock, then 30h at any address sets the mask bit for sector bits 18:16 and opens the accept window. `window_open` stays high WINDOW_CYC cycles after the last accepted 30h write, and then `erasing` is high for ERASE_CYC cycles.
- R7: While the window is open, each 30h write to an unprotected sector adds its bit to `erase_mask` and restarts the window.
- R8: While the window is open, any write whose data is neither 30h nor B0h closes the window, clears `erase_mask` and returns to read mode.
- R9: B0h at any address during the window or during a sector erase raises `suspended` and drops `window_open`/`erasing`. B0h is ignored during a whole-array erase and during a program.
- R10: While suspended, 30h at any address resumes the erase with its remaining cycle count. F0h, B0h and other writes are ignored. A program sequence to a sector outside `erase_mask` runs (`programming` high with `suspended` still high), and one to a sector in `erase_mask` is ignored.
- R11: While a program or erase is running, writes other than those named in R9 are ignored, and `erase_mask`, `prog_addr` and `prog_data` hold.
- R12: A program to, or a 30h queued for, a sector whose `prot` bit is set is ignored: no programming, and no mask bit or window restart.
- R13: F0h at any address returns to read mode from identification mode and from a partly written unlock prefix.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Host write present this cycle |
| wr_ready | output | 1 | Always high; writes never stall |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | 8 | Write data / command byte |
| prot | input | NSECT | Per-sector protect bits |
| rd_addr | input | ADDR_W | Read address for identification codes |
| asel_code | output | 8 | Identification read data |
| asel_mode | output | 1 | Identification mode active |
| window_open | output | 1 | Sector erase accept window open |
| erasing | output | 1 | Erase running |
| programming | output | 1 | Byte program running |
| suspended | output | 1 | Sector erase suspended |
| erase_mask | output | NSECT | Sectors queued or under erase |
| prog_addr | output | ADDR_W | Latched program address |
| prog_data | output | 8 | Latched program data |

## Verification
The hardest state to reach from the ports is a program running inside a suspended sector erase. Getting there needs a six-write erase prefix, expiry of the accept window, a B0h write partway through the erase, and a full unlock-and-program sequence. The bench drives that chain directly. It then checks that a program aimed at the suspended sector is refused and one aimed elsewhere runs. Last, it checks that resume completes only the cycles that were left. A behavioural model with cycle-deadline integers predicts every output on every clock, so an extra or missing countdown cycle shows up at once.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
  localparam int BYTE_W = 8;
  localparam int KEY_W  = 15;

  localparam logic [BYTE_W-1:0] CMD_UNLK_A = 8'hAA;
  localparam logic [BYTE_W-1:0] CMD_UNLK_B = 8'h55;
  localparam logic [BYTE_W-1:0] CMD_IDENT  = 8'h90;
  localparam logic [BYTE_W-1:0] CMD_PROG   = 8'hA0;
  localparam logic [BYTE_W-1:0] CMD_SETUP  = 8'h80;
  localparam logic [BYTE_W-1:0] CMD_CHIP   = 8'h10;
  localparam logic [BYTE_W-1:0] CMD_SECT   = 8'h30;
  localparam logic [BYTE_W-1:0] CMD_HOLD   = 8'hB0;
  localparam logic [BYTE_W-1:0] CMD_RESET  = 8'hF0;

  localparam logic [KEY_W-1:0] KEY_FIRST  = 15'h5555;
  localparam logic [KEY_W-1:0] KEY_SECOND = 15'h2AAA;

  typedef enum logic [3:0] {
    ST_READ, ST_U1, ST_U2, ST_IDENT,
    ST_PADDR, ST_PRUN, ST_E0, ST_E1,
    ST_E2, ST_WIN, ST_ERUN, ST_SUSP,
    ST_SU1, ST_SU2, ST_SPADDR, ST_SPRUN
  } fc_state_t;
endpackage

// File: rtl/fc_match.sv
module fc_match
  import flash_cmd_pkg::*;
(
  input  logic [KEY_W-1:0]  key,
  input  logic [BYTE_W-1:0] data,
  output logic              unlk_a,
  output logic              unlk_b,
  output logic              at_first
);
  assign at_first = (key == KEY_FIRST);
  assign unlk_a   = at_first && (data == CMD_UNLK_A);
  assign unlk_b   = (key == KEY_SECOND) && (data == CMD_UNLK_B);
endmodule

// File: rtl/fc_countdown.sv
module fc_countdown #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         en,
  output logic         expire
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)                 cnt <= '0;
    else if (load)              cnt <= load_val;
    else if (en && cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign expire = en && (cnt == W'(1));
endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W     = 19,
  parameter int SECT_W     = 3,
  parameter int WINDOW_CYC = 4000,
  parameter int ERASE_CYC  = 100000,
  parameter int PROG_CYC   = 800
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_valid,
  output logic                     wr_ready,
  input  logic [ADDR_W-1:0]        wr_addr,
  input  logic [BYTE_W-1:0]        wr_data,
  input  logic [(1<<SECT_W)-1:0]   prot,
  input  logic [ADDR_W-1:0]        rd_addr,
  output logic [BYTE_W-1:0]        asel_code,
  output logic                     asel_mode,
  output logic                     window_open,
  output logic                     erasing,
  output logic                     programming,
  output logic                     suspended,
  output logic [(1<<SECT_W)-1:0]   erase_mask,
  output logic [ADDR_W-1:0]        prog_addr,
  output logic [BYTE_W-1:0]        prog_data
);
  localparam int NSECT = 1 << SECT_W;
  localparam int OFS_W = ADDR_W - SECT_W;
  localparam int MAXC  = (WINDOW_CYC > ERASE_CYC) ?
                         ((WINDOW_CYC > PROG_CYC) ? WINDOW_CYC : PROG_CYC) :
                         ((ERASE_CYC > PROG_CYC) ? ERASE_CYC : PROG_CYC);
  localparam int CW    = $clog2(MAXC + 1);

  fc_state_t          st, nxt;
  logic [NSECT-1:0]   mask_q, mask_n;
  logic               chip_q, chip_n;
  logic               win_load, ers_load, prg_load, latch_prog;
  logic               win_exp, ers_exp, prg_exp;
  logic               m_ua, m_ub, m_key;
  logic [SECT_W-1:0]  wsec, rsec;
  logic [NSECT-1:0]   wsec_bit;
  logic               wsec_prot, wv;

  assign wv       = wr_valid;
  assign wsec     = wr_addr[ADDR_W-1 -: SECT_W];
  assign rsec     = rd_addr[ADDR_W-1 -: SECT_W];
  assign wsec_bit = NSECT'(1) << wsec;
  assign wsec_prot = prot[wsec];

  fc_match u_match (
    .key      (wr_addr[KEY_W-1:0]),
    .data     (wr_data),
    .unlk_a   (m_ua),
    .unlk_b   (m_ub),
    .at_first (m_key)
  );

  fc_countdown #(.W(CW)) u_win_tmr (
    .clk (clk), .rst_n (rst_n), .load (win_load),
    .load_val (CW'(WINDOW_CYC)), .en (st == ST_WIN), .expire (win_exp)
  );

  fc_countdown #(.W(CW)) u_ers_tmr (
    .clk (clk), .rst_n (rst_n), .load (ers_load),
    .load_val (CW'(ERASE_CYC)), .en (st == ST_ERUN), .expire (ers_exp)
  );

  fc_countdown #(.W(CW)) u_prg_tmr (
    .clk (clk), .rst_n (rst_n), .load (prg_load),
    .load_val (CW'(PROG_CYC)), .en (st == ST_PRUN || st == ST_SPRUN),
    .expire (prg_exp)
  );

  always_comb begin
    nxt        = st;
    mask_n     = mask_q;
    chip_n     = chip_q;
    win_load   = 1'b0;
    ers_load   = 1'b0;
    prg_load   = 1'b0;
    latch_prog = 1'b0;
    case (st)
      ST_READ:  if (wv && m_ua) nxt = ST_U1;
      ST_U1:    if (wv) nxt = m_ub ? ST_U2 : ST_READ;
      ST_U2: if (wv) begin
        nxt = ST_READ;
        if (m_key) begin
          if (wr_data == CMD_IDENT)      nxt = ST_IDENT;
          else if (wr_data == CMD_PROG)  nxt = ST_PADDR;
          else if (wr_data == CMD_SETUP) nxt = ST_E0;
        end
      end
      ST_IDENT: if (wv && wr_data == CMD_RESET) nxt = ST_READ;
      ST_PADDR: if (wv) begin
        nxt = ST_READ;
        if (!wsec_prot) begin
          nxt = ST_PRUN; prg_load = 1'b1; latch_prog = 1'b1;
        end
      end
      ST_PRUN:  if (prg_exp) nxt = ST_READ;
      ST_E0:    if (wv) nxt = m_ua ? ST_E1 : ST_READ;
      ST_E1:    if (wv) nxt = m_ub ? ST_E2 : ST_READ;
      ST_E2: if (wv) begin
        nxt = ST_READ;
        if (m_key && wr_data == CMD_CHIP && (~prot) != '0) begin
          mask_n = ~prot; chip_n = 1'b1; ers_load = 1'b1; nxt = ST_ERUN;
        end else if (wr_data == CMD_SECT && !wsec_prot) begin
          mask_n = wsec_bit; chip_n = 1'b0; win_load = 1'b1; nxt = ST_WIN;
        end
      end
      ST_WIN: begin
        if (wv && wr_data == CMD_SECT && !wsec_prot) begin
          mask_n = mask_q | wsec_bit; win_load = 1'b1;
        end else if (wv && wr_data == CMD_HOLD) begin
          nxt = ST_SUSP; ers_load = 1'b1;
        end else if (wv && wr_data != CMD_SECT) begin
          nxt = ST_READ; mask_n = '0;
        end else if (win_exp) begin
          nxt = ST_ERUN; ers_load = 1'b1;
        end
      end
      ST_ERUN: begin
        if (ers_exp) begin
          nxt = ST_READ; mask_n = '0; chip_n = 1'b0;
        end else if (wv && wr_data == CMD_HOLD && !chip_q) begin
          nxt = ST_SUSP;
        end
      end
      ST_SUSP: if (wv) begin
        if (wr_data == CMD_SECT) nxt = ST_ERUN;
        else if (m_ua)           nxt = ST_SU1;
      end
      ST_SU1:   if (wv) nxt = m_ub ? ST_SU2 : ST_SUSP;
      ST_SU2:   if (wv) nxt = (m_key && wr_data == CMD_PROG) ? ST_SPADDR : ST_SUSP;
      ST_SPADDR: if (wv) begin
        nxt = ST_SUSP;
        if (!wsec_prot && !mask_q[wsec]) begin
          nxt = ST_SPRUN; prg_load = 1'b1; latch_prog = 1'b1;
        end
      end
      ST_SPRUN: if (prg_exp) nxt = ST_SUSP;
      default:  nxt = ST_READ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= ST_READ;
      mask_q    <= '0;
      chip_q    <= 1'b0;
      prog_addr <= '0;
      prog_data <= '0;
    end else begin
      st     <= nxt;
      mask_q <= mask_n;
      chip_q <= chip_n;
      if (latch_prog) begin
        prog_addr <= wr_addr;
        prog_data <= wr_data;
      end
    end
  end

  logic ofs_hit;
  assign ofs_hit = (rd_addr[OFS_W-1:0] == OFS_W'(2));

  assign wr_ready    = 1'b1;
  assign asel_mode   = (st == ST_IDENT);
  assign asel_code   = (asel_mode && ofs_hit) ? {7'b0, prot[rsec]} : 8'h00;
  assign window_open = (st == ST_WIN);
  assign erasing     = (st == ST_ERUN);
  assign programming = (st == ST_PRUN) || (st == ST_SPRUN);
  assign suspended   = (st == ST_SUSP) || (st == ST_SU1) || (st == ST_SU2) ||
                       (st == ST_SPADDR) || (st == ST_SPRUN);
  assign erase_mask  = mask_q;
endmodule

// File: rtl/fc_checker.sv
module fc_checker #(
  parameter int NSECT  = 8,
  parameter int ADDR_W = 19
) (
  input logic              clk,
  input logic              rst_n,
  input logic              window_open,
  input logic              erasing,
  input logic              programming,
  input logic              suspended,
  input logic              asel_mode,
  input logic [NSECT-1:0]  erase_mask,
  input logic [ADDR_W-1:0] prog_addr,
  input logic [7:0]        prog_data
);
  AST_ONE_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({window_open, erasing, asel_mode, suspended})); // R9
  AST_SUSP_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(suspended) |-> ($past(window_open) || $past(erasing))); // R9
  AST_MASK_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (window_open || erasing || suspended) |-> (erase_mask != '0)); // R6
  AST_WIN_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(window_open) && erase_mask != '0) |-> (erasing || suspended)); // R6
  AST_PROG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (programming && $past(programming)) |-> ($stable(prog_addr) && $stable(prog_data))); // R11
  AST_RUN_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (erasing && $past(erasing)) |-> $stable(erase_mask)); // R11
  AST_PROG_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
    programming |-> !(window_open || erasing || asel_mode)); // R11
endmodule

bind flash_cmd_ctrl fc_checker #(.NSECT(NSECT), .ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .window_open (window_open),
  .erasing     (erasing),
  .programming (programming),
  .suspended   (suspended),
  .asel_mode   (asel_mode),
  .erase_mask  (erase_mask),
  .prog_addr   (prog_addr),
  .prog_data   (prog_data)
);

// File: tb/flash_cmd_ctrl_tb.sv
module flash_cmd_ctrl_tb;
  localparam int AW = 19;
  localparam int WIN = 12;
  localparam int ERS = 30;
  localparam int PRG = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_valid = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] prot = 8'b0010_0100;
  logic [AW-1:0] rd_addr = '0;
  logic wr_ready, asel_mode, window_open, erasing, programming, suspended;
  logic [7:0] asel_code, erase_mask, prog_data;
  logic [AW-1:0] prog_addr;

  always #10 clk = ~clk;

  flash_cmd_ctrl #(.WINDOW_CYC(WIN), .ERASE_CYC(ERS), .PROG_CYC(PRG)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .prot(prot), .rd_addr(rd_addr),
    .asel_code(asel_code), .asel_mode(asel_mode), .window_open(window_open),
    .erasing(erasing), .programming(programming), .suspended(suspended),
    .erase_mask(erase_mask), .prog_addr(prog_addr), .prog_data(prog_data)
  );

  int n_cmp = 0, n_bad = 0, cyc = 0;
  string cur_req = "R1";
  bit done = 0;

  // behavioural reference: mode names and deadline/remaining integers
  localparam int M_RD = 0, M_U1 = 1, M_U2 = 2, M_ID = 3, M_PA = 4, M_PR = 5,
                 M_E0 = 6, M_E1 = 7, M_E2 = 8, M_WN = 9, M_ER = 10,
                 M_SS = 11, M_S1 = 12, M_S2 = 13, M_SA = 14, M_SP = 15;
  int mode = M_RD, w_dead = 0, e_left = 0, p_left = 0;
  bit whole = 0;
  logic [7:0] m_mask = '0, m_pdat = '0;
  logic [AW-1:0] m_padr = '0;

  function automatic bit is_a(logic [AW-1:0] a, logic [7:0] d);
    return a[14:0] == 15'h5555 && d == 8'hAA;
  endfunction
  function automatic bit is_b(logic [AW-1:0] a, logic [7:0] d);
    return a[14:0] == 15'h2AAA && d == 8'h55;
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      mode = M_RD; m_mask = '0; m_padr = '0; m_pdat = '0; whole = 0;
    end else begin
      automatic bit v = wr_valid;
      automatic logic [AW-1:0] a = wr_addr;
      automatic logic [7:0] d = wr_data;
      automatic int s = int'(a[18:16]);
      automatic bit k = (a[14:0] == 15'h5555);
      case (mode)
        M_RD: if (v && is_a(a, d)) mode = M_U1;
        M_U1: if (v) mode = is_b(a, d) ? M_U2 : M_RD;
        M_U2: if (v) mode = !k ? M_RD : d == 8'h90 ? M_ID : d == 8'hA0 ? M_PA :
                             d == 8'h80 ? M_E0 : M_RD;
        M_ID: if (v && d == 8'hF0) mode = M_RD;
        M_PA: if (v) begin
          if (prot[s]) mode = M_RD;
          else begin mode = M_PR; p_left = PRG; m_padr = a; m_pdat = d; end
        end
        M_PR: if (p_left == 1) mode = M_RD; else p_left--;
        M_E0: if (v) mode = is_a(a, d) ? M_E1 : M_RD;
        M_E1: if (v) mode = is_b(a, d) ? M_E2 : M_RD;
        M_E2: if (v) begin
          mode = M_RD;
          if (k && d == 8'h10 && prot != 8'hFF) begin
            m_mask = ~prot; whole = 1; e_left = ERS; mode = M_ER;
          end else if (d == 8'h30 && !prot[s]) begin
            m_mask = 8'(1 << s); whole = 0; w_dead = cyc + WIN; mode = M_WN;
          end
        end
        M_WN: begin
          if (v && d == 8'h30 && !prot[s]) begin
            m_mask[s] = 1'b1; w_dead = cyc + WIN;
          end else if (v && d == 8'hB0) begin
            mode = M_SS; e_left = ERS;
          end else if (v && d != 8'h30) begin
            mode = M_RD; m_mask = '0;
          end else if (cyc == w_dead) begin
            mode = M_ER; e_left = ERS;
          end
        end
        M_ER: if (e_left == 1) begin mode = M_RD; m_mask = '0; whole = 0; end
              else begin e_left--; if (v && d == 8'hB0 && !whole) mode = M_SS; end
        M_SS: if (v) begin
          if (d == 8'h30) mode = M_ER; else if (is_a(a, d)) mode = M_S1;
        end
        M_S1: if (v) mode = is_b(a, d) ? M_S2 : M_SS;
        M_S2: if (v) mode = (k && d == 8'hA0) ? M_SA : M_SS;
        M_SA: if (v) begin
          if (prot[s] || m_mask[s]) mode = M_SS;
          else begin mode = M_SP; p_left = PRG; m_padr = a; m_pdat = d; end
        end
        M_SP: if (p_left == 1) mode = M_SS; else p_left--;
        default: mode = M_RD;
      endcase
    end
  end

  task automatic chk(string req, logic [63:0] got, logic [63:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s at cycle %0d: actual=%0h expected=%0h", req, cyc, got, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      automatic logic [7:0] e_code;
      automatic logic [63:0] g, e;
      e_code = (mode == M_ID && rd_addr[15:0] == 16'h0002) ? {7'b0, prot[rd_addr[18:16]]} : 8'h00;
      g = {wr_ready, asel_mode, window_open, erasing, programming, suspended,
           asel_code, erase_mask, prog_data, prog_addr};
      e = {1'b1, mode == M_ID, mode == M_WN, mode == M_ER, mode == M_PR || mode == M_SP,
           mode >= M_SS, e_code, m_mask, m_pdat, m_padr};
      chk(cur_req, g, e);
    end
  end

  task automatic wr(logic [AW-1:0] a, logic [7:0] d);
    @(negedge clk); #2;
    wr_valid = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); #2;
    wr_valid = 1'b0;
  endtask
  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic unlock();
    wr(19'h05555, 8'hAA); wr(19'h02AAA, 8'h55);
  endtask
  task automatic erase_pre();
    unlock(); wr(19'h05555, 8'h80); unlock();
  endtask

  initial begin
    idle(3); #2 rst_n = 1'b1;
    cur_req = "R1"; idle(3);
    chk("R1", {erasing, programming, erase_mask}, '0);

    cur_req = "R2";
    wr(19'h7D555, 8'hAA); wr(19'h4AAAA, 8'h55); wr(19'h05555, 8'hA0);
    wr(19'h31234, 8'h5A); idle(2);
    chk("R2", {programming, prog_addr, prog_data}, {1'b1, 19'h31234, 8'h5A});
    idle(8);

    cur_req = "R3";
    wr(19'h05555, 8'hAA); wr(19'h02AAB, 8'h55); wr(19'h05555, 8'hA0);
    wr(19'h10000, 8'h11); idle(3);
    unlock(); wr(19'h05555, 8'h77); wr(19'h10001, 8'h12); idle(3);
    chk("R3", programming, 0);

    cur_req = "R4";
    unlock(); wr(19'h05555, 8'h90);
    #2 rd_addr = 19'h20002; idle(1);
    chk("R4", asel_code, 8'h01);
    #2 rd_addr = 19'h30002; idle(1);
    chk("R4", asel_code, 8'h00);
    #2 rd_addr = 19'h20003; idle(1);
    chk("R4", asel_code, 8'h00);
    wr(19'h00000, 8'h55); idle(1);
    chk("R4", asel_mode, 1);
    cur_req = "R13"; wr(19'h00000, 8'hF0); idle(1);
    chk("R13", asel_mode, 0);

    cur_req = "R12";
    unlock(); wr(19'h05555, 8'hA0); wr(19'h50010, 8'h33); idle(3);
    chk("R12", programming, 0);
    erase_pre(); wr(19'h20000, 8'h30); idle(2);
    chk("R12", window_open, 0);

    cur_req = "R5";
    erase_pre(); wr(19'h05555, 8'h10); idle(1);
    chk("R5", {erasing, erase_mask}, {1'b1, 8'hDB});
    cur_req = "R9"; wr(19'h00000, 8'hB0);
    chk("R9", suspended, 0);
    cur_req = "R11"; unlock(); wr(19'h05555, 8'hA0); wr(19'h10000, 8'h01);
    chk("R11", programming, 0);
    cur_req = "R5"; idle(25);
    chk("R5", erasing, 0);

    cur_req = "R6";
    erase_pre(); wr(19'h10000, 8'h30); idle(3);
    cur_req = "R7"; wr(19'h60000, 8'h30);
    chk("R7", erase_mask, 8'h42);
    wr(19'h20000, 8'h30); idle(1);
    chk("R12", erase_mask, 8'h42);
    cur_req = "R6"; idle(15);
    chk("R6", erasing, 1);
    idle(35);

    cur_req = "R8";
    erase_pre(); wr(19'h00000, 8'h30); wr(19'h05555, 8'h40); idle(2);
    chk("R8", {window_open, erase_mask}, 0);

    cur_req = "R9";
    erase_pre(); wr(19'h30000, 8'h30); idle(20);
    wr(19'h00000, 8'hB0); idle(1);
    chk("R9", {suspended, erasing}, 2'b10);
    cur_req = "R10";
    wr(19'h00000, 8'hF0);
    unlock(); wr(19'h05555, 8'hA0); wr(19'h30010, 8'h01); idle(1);
    chk("R10", {suspended, programming}, 2'b10);
    unlock(); wr(19'h05555, 8'hA0); wr(19'h40010, 8'h77); idle(1);
    chk("R10", {suspended, programming}, 2'b11);
    idle(8);
    wr(19'h00000, 8'hB0); wr(19'h12345, 8'h30); idle(1);
    chk("R10", erasing, 1);
    idle(40);

    cur_req = "R9";
    erase_pre(); wr(19'h70000, 8'h30); wr(19'h00000, 8'hB0); idle(2);
    chk("R9", {suspended, erase_mask}, {1'b1, 8'h80});
    wr(19'h00000, 8'h30); idle(40);

    unlock(); wr(19'h05555, 8'hA0); wr(19'h11111, 8'h22);
    wr(19'h00000, 8'hB0); idle(1);
    chk("R9", suspended, 0);
    idle(8);

    cur_req = "R13";
    wr(19'h05555, 8'hAA); wr(19'h00000, 8'hF0);
    unlock(); wr(19'h05555, 8'hA0); wr(19'h12345, 8'h66); idle(1);
    chk("R13", {programming, prog_data}, {1'b1, 8'h66});
    idle(10);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule